// File: doc/BRIEF.md
# DDR Read Burst Sequencer

This block models the device side of a double-data-rate memory read path so that a memory controller can be checked against it. On each accepted READ it captures the bank group, bank and starting column together with two command address bits. One bit selects the burst length when per-command selection is enabled. The other requests an automatic precharge of the bank once the burst has finished. The command's additive latency and CAS latency are sampled with it. After their sum, counted in clocks, the block delivers the burst as pairs of beats, one beat for each clock edge. The beats come from consecutive columns of a fixed internal array whose contents are a computed function of the address.

A strobe enable frames every burst with a one-clock preamble and a one-clock postamble. A data-valid flag marks exactly the clocks that carry data. After an auto-precharge read, a one-clock bank-idle pulse names the bank that has become idle. A READ aimed at a bank that is still closing is refused and flagged.

Each command carries its own latency and burst length. A READ accepted while another burst is in flight is therefore placed at its own latency. READs spaced by exactly one burst give a continuous data stream.

Top module: `ddr_rd_burst_seq`

## Requirements
- R1: While reset is asserted, and in the first clock after it is released, dq_valid, dqs_en, bank_idle and rd_err are low and both data lanes are zero.
- R2: A READ sampled in clock t produces its first beat pair in clock t+RL, where RL = max(cfg_al + cfg_cl, 2). cfg_al and cfg_cl each range over 0..31.
- R3: cfg_bl selects the burst length as follows:
  - 00 and 11 give 8 beats (4 clocks).
  - 10 gives 4 beats (2 clocks).
  - 01 takes the length from the command: rd_a12 = 1 gives 8 beats and rd_a12 = 0 gives 4 beats.
- R4: In data clock j of a burst that starts at column n, dq_rise carries column n+2j and dq_fall carries column n+2j+1. Columns wrap modulo 128.
- R5: The beat for bank index b = {rd_bg, rd_ba} and column c is 16'h5A00 XOR {b, c}, with c in bits 6:0 and b in bits 10:7.
- R6: dq_valid is high exactly in the clocks that carry burst data, and both lanes are zero in every other clock.
- R7: dqs_en is high from one clock before the first data clock to one clock after the last data clock. READs that use the same latency and are spaced by their burst length in clocks keep dq_valid and dqs_en high without a gap.
- R8: A READ with rd_a10 = 1 raises bank_idle for one clock, in the clock after its last data clock, with idle_bank equal to its bank index. A READ with rd_a10 = 0 raises no bank_idle.
- R9: A READ to a bank is refused, producing no burst and rd_err high in the next clock, from the clock that bank's auto-precharge READ is accepted through the clock of its bank_idle pulse. A refused READ does not extend that window.
- R10: Latency and burst length are taken at the command. Changing cfg_bl, cfg_al or cfg_cl while a burst is in flight does not alter that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_cmd | input | 1 | READ command strobe (low = deselect) |
| rd_bg | input | 2 | Bank group of the READ |
| rd_ba | input | 2 | Bank within the group |
| rd_col | input | 7 | Starting column |
| rd_a12 | input | 1 | Per-command burst length bit (1 = 8 beats) |
| rd_a10 | input | 1 | Auto-precharge request |
| cfg_bl | input | 2 | Burst length mode |
| cfg_al | input | 5 | Additive latency |
| cfg_cl | input | 5 | CAS latency |
| dq_rise | output | 16 | Beat driven on the rising edge |
| dq_fall | output | 16 | Beat driven on the falling edge |
| dq_valid | output | 1 | Clock carries burst data |
| dqs_en | output | 1 | Strobe driven (preamble, burst, postamble) |
| bank_idle | output | 1 | Auto-precharged bank has become idle |
| idle_bank | output | 4 | Bank index for bank_idle |
| rd_err | output | 1 | Previous READ hit a closing bank |

## Verification
The hardest corner to reach is a READ to a closing bank that lands exactly in the clock of that bank's idle pulse. While this happens, another bank's burst is running and its postamble overlaps the next preamble. The stimulus places an auto-precharge read and a plain read to a second bank one burst apart. It then issues READs to the first bank one clock after acceptance, in the idle-pulse clock itself, and one clock later. Only the last of these may be accepted. Between commands, the bench drives changing latency and burst modes on the configuration inputs. This confirms that bursts already in flight are unaffected.

// File: rtl/ddr_rd_pkg.sv
package ddr_rd_pkg;
   typedef enum logic [1:0] {
      BLM_FIX8 = 2'b00,
      BLM_SEL  = 2'b01,
      BLM_FIX4 = 2'b10,
      BLM_RSV  = 2'b11
   } bl_mode_e;

   localparam int MIN_RL     = 2;
   localparam int LONG_CLKS  = 4;
   localparam int CHOP_CLKS  = 2;
endpackage

// File: rtl/ddr_rd_decode.sv
module ddr_rd_decode
   import ddr_rd_pkg::*;
#(
   parameter int LATW = 5,
   parameter int RLW  = 6,
   parameter int NCW  = 3
) (
   input  logic [1:0]      mode,
   input  logic            sel_long,
   input  logic [LATW-1:0] al,
   input  logic [LATW-1:0] cl,
   output logic [RLW-1:0]  rl,
   output logic [NCW-1:0]  nclk
);
   logic [RLW-1:0] sum;
   logic           is_long;

   always_comb begin
      sum = RLW'(al) + RLW'(cl);
      rl  = (int'(sum) < MIN_RL) ? RLW'(MIN_RL) : sum;
      unique case (bl_mode_e'(mode))
         BLM_FIX4: is_long = 1'b0;
         BLM_SEL:  is_long = sel_long;
         default:  is_long = 1'b1;
      endcase
      nclk = is_long ? NCW'(LONG_CLKS) : NCW'(CHOP_CLKS);
   end
endmodule

// File: rtl/ddr_rd_slot.sv
module ddr_rd_slot #(
   parameter int IDX  = 0,
   parameter int BKW  = 4,
   parameter int COLW = 7,
   parameter int RLW  = 6,
   parameter int NCW  = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic [RLW-1:0]  rl,
   input  logic [NCW-1:0]  nclk,
   input  logic            ap,
   input  logic [BKW-1:0]  bank,
   input  logic [COLW-1:0] col,
   input  logic            nx_vld,
   input  logic            nx_dqs,
   input  logic            nx_idle,
   input  logic [BKW-1:0]  nx_bank,
   input  logic [COLW-1:0] nx_col,
   input  logic [BKW-1:0]  nx_ibank,
   output logic            q_vld,
   output logic            q_dqs,
   output logic            q_idle,
   output logic [BKW-1:0]  q_bank,
   output logic [COLW-1:0] q_col,
   output logic [BKW-1:0]  q_ibank
);
   int   off;
   int   rl_i;
   int   nc_i;
   logic hit_data, hit_dqs, hit_idle;

   always_comb begin
      rl_i     = int'(rl);
      nc_i     = int'(nclk);
      off      = IDX - (rl_i - 1);
      hit_data = load && (off >= 0) && (off < nc_i);
      hit_dqs  = load && (IDX >= rl_i - 2) && (IDX <= rl_i - 1 + nc_i);
      hit_idle = load && ap && (IDX == rl_i - 1 + nc_i);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_vld   <= 1'b0;
         q_dqs   <= 1'b0;
         q_idle  <= 1'b0;
         q_bank  <= '0;
         q_col   <= '0;
         q_ibank <= '0;
      end else begin
         q_vld   <= hit_data | nx_vld;
         q_bank  <= hit_data ? bank : nx_bank;
         q_col   <= hit_data ? col + COLW'(off * 2) : nx_col;
         q_dqs   <= hit_dqs | nx_dqs;
         q_idle  <= hit_idle | nx_idle;
         q_ibank <= hit_idle ? bank : nx_ibank;
      end
   end
endmodule

// File: rtl/ddr_rd_bank_track.sv
module ddr_rd_bank_track #(
   parameter int NBANK = 16,
   parameter int BKW   = 4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           req,
   input  logic [BKW-1:0] req_bank,
   input  logic           req_ap,
   input  logic           idle_pulse,
   input  logic [BKW-1:0] idle_id,
   output logic           accept,
   output logic           err_q
);
   logic [NBANK-1:0] closing_q;

   assign accept = req && !closing_q[req_bank];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         closing_q <= '0;
         err_q     <= 1'b0;
      end else begin
         err_q <= req && closing_q[req_bank];
         for (int b = 0; b < NBANK; b++) begin
            if (accept && req_ap && (int'(req_bank) == b))
               closing_q[b] <= 1'b1;
            else if (idle_pulse && (int'(idle_id) == b))
               closing_q[b] <= 1'b0;
         end
      end
   end

   // R8: an idle pulse may only name a bank that is closing
   a_r8_idle_from_closing: assert property (@(posedge clk) disable iff (!rst_n)
      idle_pulse |-> closing_q[idle_id]);
endmodule

// File: rtl/ddr_rd_burst_seq.sv
module ddr_rd_burst_seq
   import ddr_rd_pkg::*;
#(
   parameter int BGW  = 2,
   parameter int BAW  = 2,
   parameter int COLW = 7,
   parameter int DW   = 16,
   parameter int LATW = 5,
   parameter int SEED = 'h5A00
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 rd_cmd,
   input  logic [BGW-1:0]       rd_bg,
   input  logic [BAW-1:0]       rd_ba,
   input  logic [COLW-1:0]      rd_col,
   input  logic                 rd_a12,
   input  logic                 rd_a10,
   input  logic [1:0]           cfg_bl,
   input  logic [LATW-1:0]      cfg_al,
   input  logic [LATW-1:0]      cfg_cl,
   output logic [DW-1:0]        dq_rise,
   output logic [DW-1:0]        dq_fall,
   output logic                 dq_valid,
   output logic                 dqs_en,
   output logic                 bank_idle,
   output logic [BGW+BAW-1:0]   idle_bank,
   output logic                 rd_err
);
   localparam int BKW    = BGW + BAW;
   localparam int NBANK  = 1 << BKW;
   localparam int RLW    = LATW + 1;
   localparam int NCW    = $clog2(LONG_CLKS + 1);
   localparam int MAXRL  = 2 * ((1 << LATW) - 1);
   localparam int DEPTH  = MAXRL + LONG_CLKS;

   if (DW < BKW + COLW) begin : g_bad_dw
      $error("data width cannot hold bank and column");
   end
   if (MAXRL < MIN_RL) begin : g_bad_lat
      $error("latency field too narrow");
   end

   logic [RLW-1:0] rl;
   logic [NCW-1:0] nclk;
   logic [BKW-1:0] bank;
   logic           accept;

   assign bank = {rd_bg, rd_ba};

   ddr_rd_decode #(.LATW(LATW), .RLW(RLW), .NCW(NCW)) u_dec (
      .mode(cfg_bl), .sel_long(rd_a12), .al(cfg_al), .cl(cfg_cl),
      .rl(rl), .nclk(nclk)
   );

   logic            s_vld   [DEPTH+1];
   logic            s_dqs   [DEPTH+1];
   logic            s_idle  [DEPTH+1];
   logic [BKW-1:0]  s_bank  [DEPTH+1];
   logic [COLW-1:0] s_col   [DEPTH+1];
   logic [BKW-1:0]  s_ibank [DEPTH+1];

   assign s_vld[DEPTH]   = 1'b0;
   assign s_dqs[DEPTH]   = 1'b0;
   assign s_idle[DEPTH]  = 1'b0;
   assign s_bank[DEPTH]  = '0;
   assign s_col[DEPTH]   = '0;
   assign s_ibank[DEPTH] = '0;

   for (genvar k = 0; k < DEPTH; k++) begin : g_slot
      ddr_rd_slot #(.IDX(k), .BKW(BKW), .COLW(COLW), .RLW(RLW), .NCW(NCW)) u_slot (
         .clk(clk), .rst_n(rst_n), .load(accept), .rl(rl), .nclk(nclk),
         .ap(rd_a10), .bank(bank), .col(rd_col),
         .nx_vld(s_vld[k+1]), .nx_dqs(s_dqs[k+1]), .nx_idle(s_idle[k+1]),
         .nx_bank(s_bank[k+1]), .nx_col(s_col[k+1]), .nx_ibank(s_ibank[k+1]),
         .q_vld(s_vld[k]), .q_dqs(s_dqs[k]), .q_idle(s_idle[k]),
         .q_bank(s_bank[k]), .q_col(s_col[k]), .q_ibank(s_ibank[k])
      );
   end

   ddr_rd_bank_track #(.NBANK(NBANK), .BKW(BKW)) u_trk (
      .clk(clk), .rst_n(rst_n), .req(rd_cmd), .req_bank(bank), .req_ap(rd_a10),
      .idle_pulse(s_idle[0]), .idle_id(s_ibank[0]), .accept(accept), .err_q(rd_err)
   );

   function automatic logic [DW-1:0] word_of(logic [BKW-1:0] b, logic [COLW-1:0] c);
      logic [DW-1:0] raw;
      raw = '0;
      raw[BKW+COLW-1:0] = {b, c};
      return raw ^ DW'(SEED);
   endfunction

   assign dq_valid  = s_vld[0];
   assign dqs_en    = s_dqs[0];
   assign bank_idle = s_idle[0];
   assign idle_bank = s_ibank[0];
   assign dq_rise   = s_vld[0] ? word_of(s_bank[0], s_col[0]) : '0;
   assign dq_fall   = s_vld[0] ? word_of(s_bank[0], s_col[0] + COLW'(1)) : '0;

   // R6: data only while the strobe is driven
   a_r6_valid_in_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      dq_valid |-> dqs_en);
   // R7: preamble precedes the first data clock
   a_r7_preamble: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dq_valid) |-> $past(dqs_en));
   // R7: postamble follows the last data clock
   a_r7_postamble: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dq_valid) |-> dqs_en);
   // R9: an error only follows a command
   a_r9_err_after_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      rd_err |-> $past(rd_cmd));
endmodule

// File: tb/ddr_rd_burst_seq_test.sv
module ddr_rd_burst_seq_test;
   localparam int W = 4096;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rd_cmd = 1'b0;
   logic [1:0]  rd_bg = '0, rd_ba = '0;
   logic [6:0]  rd_col = '0;
   logic        rd_a12 = 1'b0, rd_a10 = 1'b0;
   logic [1:0]  cfg_bl = '0;
   logic [4:0]  cfg_al = '0, cfg_cl = '0;
   logic [15:0] dq_rise, dq_fall;
   logic        dq_valid, dqs_en, bank_idle, rd_err;
   logic [3:0]  idle_bank;

   always #2.5 clk = ~clk;

   ddr_rd_burst_seq uut (
      .clk(clk), .rst_n(rst_n), .rd_cmd(rd_cmd), .rd_bg(rd_bg), .rd_ba(rd_ba),
      .rd_col(rd_col), .rd_a12(rd_a12), .rd_a10(rd_a10), .cfg_bl(cfg_bl),
      .cfg_al(cfg_al), .cfg_cl(cfg_cl), .dq_rise(dq_rise), .dq_fall(dq_fall),
      .dq_valid(dq_valid), .dqs_en(dqs_en), .bank_idle(bank_idle),
      .idle_bank(idle_bank), .rd_err(rd_err)
   );

   int cyc = 0, checks = 0, failures = 0;
   bit done = 0;
   bit e_dv [W] = '{default: 0};
   bit e_dqs [W] = '{default: 0};
   bit e_idle [W] = '{default: 0};
   bit e_err [W] = '{default: 0};
   logic [15:0] e_r [W] = '{default: 0};
   logic [15:0] e_f [W] = '{default: 0};
   logic [3:0]  e_ib [W] = '{default: 0};
   int close_until [16] = '{default: -1};

   function automatic logic [15:0] word(int b, int c);
      return 16'h5A00 ^ 16'((b << 7) | (c % 128));
   endfunction

   task automatic chk(bit ok, string req, string what, int act, int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s cycle %0d actual=%0h expected=%0h", req, what, cyc, act, exp);
      end
   endtask

   task automatic compare();
      chk(dq_valid === e_dv[cyc], "R6", "dq_valid", int'(dq_valid), int'(e_dv[cyc]));
      chk(dq_rise === e_r[cyc], "R4/R5", "dq_rise", int'(dq_rise), int'(e_r[cyc]));
      chk(dq_fall === e_f[cyc], "R4/R5", "dq_fall", int'(dq_fall), int'(e_f[cyc]));
      chk(dqs_en === e_dqs[cyc], "R7", "dqs_en", int'(dqs_en), int'(e_dqs[cyc]));
      chk(bank_idle === e_idle[cyc], "R8", "bank_idle", int'(bank_idle), int'(e_idle[cyc]));
      if (e_idle[cyc])
         chk(idle_bank === e_ib[cyc], "R8", "idle_bank", int'(idle_bank), int'(e_ib[cyc]));
      chk(rd_err === e_err[cyc], "R9", "rd_err", int'(rd_err), int'(e_err[cyc]));
   endtask

   // one idle clock; configuration inputs wander to exercise R10
   task automatic nop(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (rst_n) compare();
         else begin
            // R1: outputs quiet during reset
            chk(!dq_valid && !dqs_en && !bank_idle && !rd_err && dq_rise == 0 && dq_fall == 0,
                "R1", "reset outputs", int'({dq_valid, dqs_en, bank_idle, rd_err}), 0);
         end
         rd_cmd = 1'b0;
         cfg_bl = 2'(cyc);
         cfg_al = 5'(cyc * 7);
         cfg_cl = 5'(cyc * 3);
         rd_col = 7'(cyc * 5);
         rd_a12 = cyc[0];
         rd_a10 = cyc[1];
         @(posedge clk);
         cyc++;
      end
   endtask

   task automatic rd(int bg, int ba, int col, bit a12, bit a10, int mode, int al, int cl);
      int b, t, rl, n;
      @(negedge clk);
      compare();
      rd_cmd = 1'b1; rd_bg = 2'(bg); rd_ba = 2'(ba); rd_col = 7'(col);
      rd_a12 = a12; rd_a10 = a10; cfg_bl = 2'(mode); cfg_al = 5'(al); cfg_cl = 5'(cl);
      t = cyc;
      b = bg * 4 + ba;
      if (close_until[b] >= t) e_err[t+1] = 1;
      else begin
         rl = (al + cl < 2) ? 2 : al + cl;                       // R2
         n = (mode == 2 || (mode == 1 && !a12)) ? 2 : 4;         // R3
         for (int j = 0; j < n; j++) begin
            e_dv[t+rl+j] = 1;
            e_r[t+rl+j] = word(b, col + 2*j);
            e_f[t+rl+j] = word(b, col + 2*j + 1);
         end
         for (int c = t + rl - 1; c <= t + rl + n; c++) e_dqs[c] = 1;
         if (a10) begin
            e_idle[t+rl+n] = 1;
            e_ib[t+rl+n] = 4'(b);
            close_until[b] = t + rl + n;
         end
      end
      @(posedge clk);
      cyc++;
   endtask

   initial begin
      @(posedge clk);
      cyc++;
      nop(3);
      @(negedge clk);
      rst_n = 1'b1;
      nop(2);
      // R2 R3 fixed long burst, CL 11
      rd(1, 2, 5, 0, 0, 0, 0, 11);
      nop(18);
      // R3 R4 per-command chop with column wrap, AL 3 CL 5
      rd(2, 1, 126, 0, 0, 1, 3, 5);
      nop(14);
      // R3 selected long burst
      rd(0, 3, 40, 1, 0, 1, 2, 2);
      nop(10);
      // R3 fixed chop ignores a12; R2 latency clamp at zero
      rd(3, 0, 9, 1, 0, 2, 0, 0);
      nop(8);
      // R3 reserved mode gives long burst
      rd(1, 1, 77, 0, 0, 3, 1, 1);
      nop(10);
      // R7 gapless long bursts
      rd(0, 0, 0, 0, 0, 0, 2, 4);
      nop(3);
      rd(0, 1, 8, 0, 0, 0, 2, 4);
      nop(3);
      rd(3, 3, 120, 0, 0, 0, 2, 4);
      nop(3);
      // R7 gapless chops
      rd(2, 2, 16, 0, 0, 1, 1, 5);
      nop(1);
      rd(2, 3, 20, 0, 0, 2, 1, 5);
      nop(14);
      // R8 R9 closing-bank window
      rd(0, 3, 30, 1, 1, 0, 0, 4);
      rd(0, 3, 50, 1, 0, 0, 0, 4);
      nop(2);
      rd(1, 1, 60, 1, 0, 0, 0, 4);
      nop(3);
      rd(0, 3, 70, 1, 0, 0, 0, 4);
      rd(0, 3, 90, 1, 0, 0, 0, 4);
      nop(14);
      // R10 long latency with config wandering in flight; R8 chop with precharge
      rd(3, 1, 100, 0, 1, 1, 31, 31);
      nop(72);
      rd(3, 1, 3, 0, 0, 0, 31, 31);
      nop(70);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule